// File: doc/BRIEF.md
# Selectable Bit-Clock Generator with Command-Mode Rate Change

This block turns the system clock into a single-cycle enable pulse at sixteen times the serial bit rate. It serves an infrared encoder/decoder and the UART that feeds it. Five bit rates are available. The fastest bit period is `BASE_DIV` system clocks, and the slower ones are 2, 3, 6 and 12 times that. A three-bit select input either picks a rate directly or hands the choice to software.

Software selection is active while the select input reads `111`. While it is active, driving the mode input low puts the block into command mode. In command mode the infrared encoding and decoding are switched off (`codec_en_o` low), and every byte the UART receiver delivers is requested for echo back to the controller. A byte that names a rate is held as the pending choice. The commit byte `0x11` arms a change. The pending rate then becomes active when the UART transmitter reports that the stop bit of the echo has finished.

Top module: `baud_cmd_gen`

## Requirements
- R1: After reset, `rate_o` is 0 (slowest rate), `echo_req_o` is low and `codec_en_o` is high.
- R2: Select codes 000, 001, 010, 011 and 100 give `rate_o` equal to the select value. The `tick_o` spacing is then BASE_DIV*M/TICKS_PER_BIT clocks, where M is 12, 6, 3, 2 and 1 for those codes (48, 24, 12, 8 and 4 clocks with the defaults).
- R3: The unused select codes 101 and 110 run at rate 0.
- R4: Select code 111 enables software selection. The active rate starts at rate 0 each time software selection is entered.
- R5: Command mode is select 111 with `mode_i` low. `codec_en_o` is low in command mode and high otherwise.
- R6: A byte strobe (`rx_valid_i`) in command mode raises `echo_req_o` for exactly one cycle, in the cycle after the strobe. No echo is requested outside command mode.
- R7: In command mode, bytes 0x87, 0x8B, 0x85, 0x83 and 0x81 set the pending rate to 0, 1, 2, 3 and 4. Any other byte leaves the pending rate unchanged.
- R8: Byte 0x11 arms a commit. The active rate changes to the pending rate only at an `echo_done_i` pulse after arming. `rate_o` shows the new rate by the second clock after that pulse.
- R9: Bytes received outside command mode neither change the pending rate nor arm a commit.
- R10: Changing the select input away from 111 overrides a software-chosen rate on the next clock edge.
- R11: `tick_o` pulses last one cycle. A change of rate restarts the divider, so the spacing between ticks matches the new rate from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sel_i | input | 3 | Rate select; 111 hands the choice to software |
| mode_i | input | 1 | High: data mode; low: command mode (with select 111) |
| rx_valid_i | input | 1 | One-cycle strobe: a byte arrived from the controller |
| rx_data_i | input | 8 | The received byte |
| echo_done_i | input | 1 | One-cycle strobe: stop bit of the echoed byte finished |
| tick_o | output | 1 | Sixteen-times bit-clock enable pulse |
| echo_req_o | output | 1 | Request to echo the last received byte |
| rate_o | output | 3 | Active rate index, 0 (slowest) to 4 (fastest) |
| codec_en_o | output | 1 | High when infrared encoding/decoding may run |

## Verification
The bench keeps the default parameters, `BASE_DIV` = 64 and `TICKS_PER_BIT` = 16. With these values the tick spacings are 48, 24, 12, 8 and 4 clocks, so the spacing at every rate can be measured exactly between two consecutive ticks in under a hundred cycles. This short spacing also makes it practical to walk the whole command sequence: a rate byte, a reserved byte, the commit byte, and then the echo-complete strobe. After each step the bench checks whether the rate has moved.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

  typedef logic [2:0] rate_t;

  typedef struct packed {
    logic  ok;
    rate_t idx;
  } rate_dec_t;

  localparam logic [7:0] COMMIT_BYTE = 8'h11;
  localparam logic [2:0] SW_SELECT   = 3'b111;

  // Multiple of the fastest bit period for each rate index.
  function automatic int unsigned rate_mult(rate_t r);
    case (r)
      3'd0:    rate_mult = 12;
      3'd1:    rate_mult = 6;
      3'd2:    rate_mult = 3;
      3'd3:    rate_mult = 2;
      3'd4:    rate_mult = 1;
      default: rate_mult = 12;
    endcase
  endfunction

  // Software rate byte to index; ok is low for every other byte.
  function automatic rate_dec_t decode_rate_byte(logic [7:0] b);
    rate_dec_t d;
    d.ok = 1'b1;
    case (b)
      8'h87:   d.idx = 3'd0;
      8'h8B:   d.idx = 3'd1;
      8'h85:   d.idx = 3'd2;
      8'h83:   d.idx = 3'd3;
      8'h81:   d.idx = 3'd4;
      default: begin d.ok = 1'b0; d.idx = 3'd0; end
    endcase
    return d;
  endfunction

  // Pin select to index; unused codes fall back to the slowest rate.
  function automatic rate_t pin_rate(logic [2:0] s);
    return (s <= 3'd4) ? s : 3'd0;
  endfunction

endpackage

// File: rtl/bgc_sw_ctrl.sv
module bgc_sw_ctrl
  import bgc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_mode_i,
  input  logic       cmd_mode_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       echo_done_i,
  output rate_t      sw_rate_o,
  output logic       echo_o,
  output logic       commit_o
);

  rate_t     sw_rate_q, pend_q;
  logic      armed_q, echo_q;
  rate_dec_t dec;
  logic      cmd_byte;

  assign dec      = decode_rate_byte(rx_data_i);
  assign cmd_byte = rx_valid_i && cmd_mode_i;
  assign commit_o = sw_mode_i && echo_done_i && armed_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sw_rate_q <= '0;
      pend_q    <= '0;
      armed_q   <= 1'b0;
      echo_q    <= 1'b0;
    end else begin
      echo_q <= cmd_byte;
      if (!sw_mode_i) begin
        sw_rate_q <= '0;
        pend_q    <= '0;
        armed_q   <= 1'b0;
      end else begin
        if (commit_o) begin
          sw_rate_q <= pend_q;
          armed_q   <= 1'b0;
        end
        if (cmd_byte) begin
          if (dec.ok) pend_q <= dec.idx;
          if (rx_data_i == COMMIT_BYTE) armed_q <= 1'b1;
        end
      end
    end
  end

  assign sw_rate_o = sw_rate_q;
  assign echo_o    = echo_q;

  // R6: an echo request always traces back to a command-mode byte
  p_echo_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    echo_q |-> $past(rx_valid_i && cmd_mode_i));

  // R7: the pending rate moves only on a valid rate byte in command mode
  p_pending_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_mode_i && $past(sw_mode_i) && pend_q != $past(pend_q))
      |-> $past(rx_valid_i && cmd_mode_i && dec.ok));

  // R8: the active software rate moves only on an armed echo-complete strobe
  p_commit_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_mode_i && $past(sw_mode_i) && sw_rate_q != $past(sw_rate_q))
      |-> $past(echo_done_i && armed_q));

endmodule

// File: rtl/bgc_tick_gen.sv
module bgc_tick_gen
  import bgc_pkg::*;
#(
  parameter int unsigned BASE_DIV      = 64,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rate_t rate_i,
  output logic  tick_o,
  output rate_t rate_o
);

  localparam int unsigned MAX_PER = BASE_DIV * 12 / TICKS_PER_BIT;
  localparam int unsigned CW      = $clog2(MAX_PER + 1);

  function automatic logic [CW-1:0] reload_of(rate_t r);
    return CW'(BASE_DIV * rate_mult(r) / TICKS_PER_BIT - 1);
  endfunction

  logic [CW-1:0] cnt_q;
  rate_t         rate_q;
  logic          tick_q;
  logic          rate_chg;

  assign rate_chg = (rate_i != rate_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= reload_of(3'd0);
      rate_q <= 3'd0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (rate_chg) begin
        rate_q <= rate_i;
        cnt_q  <= reload_of(rate_i);
      end else if (cnt_q == '0) begin
        cnt_q  <= reload_of(rate_q);
        tick_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign tick_o = tick_q;
  assign rate_o = rate_q;

  // Checker state: cycles since the last tick, and whether the rate moved.
  logic [CW:0] gap_q;
  logic        chg_seen_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      gap_q      <= '0;
      chg_seen_q <= 1'b1;
    end else begin
      gap_q <= tick_q ? (CW+1)'(1) : gap_q + 1'b1;
      if (rate_chg)    chg_seen_q <= 1'b1;
      else if (tick_q) chg_seen_q <= 1'b0;
    end
  end

  // R11: ticks last one cycle
  p_tick_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);

  // R11: steady-rate tick spacing equals the rate's period
  p_tick_spacing_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q && !chg_seen_q)
      |-> gap_q == (CW+1)'(BASE_DIV * rate_mult(rate_q) / TICKS_PER_BIT));

  // R2: the active index never leaves the five defined rates
  p_rate_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_q <= 3'd4);

endmodule

// File: rtl/baud_cmd_gen.sv
module baud_cmd_gen
  import bgc_pkg::*;
#(
  parameter int unsigned BASE_DIV      = 64,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       mode_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       echo_done_i,
  output logic       tick_o,
  output logic       echo_req_o,
  output logic [2:0] rate_o,
  output logic       codec_en_o
);

  logic  sw_mode, cmd_mode, commit;
  rate_t sw_rate, rate_eff;

  assign sw_mode    = (sel_i == SW_SELECT);
  assign cmd_mode   = sw_mode && !mode_i;
  assign codec_en_o = !cmd_mode;
  assign rate_eff   = sw_mode ? sw_rate : pin_rate(sel_i);

  bgc_sw_ctrl u_sw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_mode_i   (sw_mode),
    .cmd_mode_i  (cmd_mode),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .echo_done_i (echo_done_i),
    .sw_rate_o   (sw_rate),
    .echo_o      (echo_req_o),
    .commit_o    (commit)
  );

  bgc_tick_gen #(
    .BASE_DIV      (BASE_DIV),
    .TICKS_PER_BIT (TICKS_PER_BIT)
  ) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rate_i (rate_eff),
    .tick_o (tick_o),
    .rate_o (rate_o)
  );

  // R10: a stable pin select is reflected one edge later
  p_pin_override_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !sw_mode && $past(sel_i) == sel_i)
      |-> rate_o == pin_rate(sel_i));

  // R8: a commit pulse only happens in software selection
  p_commit_sw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> sw_mode);

endmodule

// File: tb/sim_baud_cmd_gen.sv
module sim_baud_cmd_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       mode = 1'b1;
  logic       rxv = 1'b0;
  logic [7:0] rxd = 8'h00;
  logic       edone = 1'b0;
  logic       tick, echo, cen;
  logic [2:0] rate;

  int n_tests = 0;
  int n_fail  = 0;
  bit timed_out = 0;

  always #4 clk = ~clk;

  baud_cmd_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .mode_i(mode),
    .rx_valid_i(rxv), .rx_data_i(rxd), .echo_done_i(edone),
    .tick_o(tick), .echo_req_o(echo), .rate_o(rate), .codec_en_o(cen)
  );

  // {sel, expected rate, expected tick spacing}
  localparam logic [12:0] VEC [8] = '{
    {3'd0, 3'd0, 7'd48}, {3'd1, 3'd1, 7'd24}, {3'd2, 3'd2, 7'd12},
    {3'd3, 3'd3, 7'd8},  {3'd4, 3'd4, 7'd4},  {3'd5, 3'd0, 7'd48},
    {3'd6, 3'd0, 7'd48}, {3'd7, 3'd0, 7'd48}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Spacing between two consecutive ticks, in clocks.
  task automatic spacing(output int gap);
    int guard = 0;
    gap = 0;
    while (!tick && guard < 500) begin @(negedge clk); guard++; end
    @(negedge clk); gap = 1;
    while (!tick && gap < 500) begin @(negedge clk); gap++; end
  endtask

  task automatic send(input logic [7:0] b, input bit exp_echo, input string tag);
    @(negedge clk); rxv = 1'b1; rxd = b;
    @(negedge clk); rxv = 1'b0;
    check(echo == exp_echo, tag, echo, exp_echo);
    @(negedge clk);
    check(echo == 1'b0, tag, echo, 0);
  endtask

  task automatic echo_complete();
    @(negedge clk); edone = 1'b1;
    @(negedge clk); edone = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int g;
    // R1: reset state
    cyc(3); rst_n = 1'b1; @(negedge clk);
    check(rate == 3'd0, "R1 rate", rate, 0);
    check(echo == 1'b0, "R1 echo", echo, 0);
    check(cen == 1'b1, "R1 codec_en", cen, 1);

    // R2/R3/R4: pin table walk
    for (int i = 0; i < 8; i++) begin
      sel = VEC[i][12:10];
      cyc(3);
      check(rate == VEC[i][9:7], "R2/R3/R4 rate", rate, VEC[i][9:7]);
      spacing(g);
      check(g == int'(VEC[i][6:0]), "R2/R11 spacing", g, VEC[i][6:0]);
    end

    // R5: command mode entry (sel is 111 here)
    mode = 1'b0; @(negedge clk);
    check(cen == 1'b0, "R5 codec_en cmd", cen, 0);

    // R6/R7/R8: pick /192 then commit
    send(8'h85, 1'b1, "R6 echo rate byte");
    check(rate == 3'd0, "R7 pending not active", rate, 0);
    send(8'h11, 1'b1, "R6 echo commit byte");
    cyc(10);
    check(rate == 3'd0, "R8 no change before echo done", rate, 0);
    echo_complete();
    check(rate == 3'd2, "R8 commit applied", rate, 2);
    spacing(g);
    check(g == 12, "R11 spacing after commit", g, 12);

    // R7: reserved byte ignored, last valid code wins
    send(8'h8B, 1'b1, "R6 echo");
    send(8'h55, 1'b1, "R6 echo reserved");
    send(8'h11, 1'b1, "R6 echo commit");
    echo_complete();
    check(rate == 3'd1, "R7 reserved ignored", rate, 1);

    // R8: echo done without arming does nothing
    send(8'h81, 1'b1, "R6 echo");
    echo_complete();
    check(rate == 3'd1, "R8 unarmed echo done", rate, 1);

    // R9/R6/R5: data mode bytes ignored, no echo
    mode = 1'b1; @(negedge clk);
    check(cen == 1'b1, "R5 codec_en data", cen, 1);
    send(8'h83, 1'b0, "R6 no echo in data mode");
    send(8'h11, 1'b0, "R6 no echo in data mode");
    echo_complete();
    check(rate == 3'd1, "R9 data-mode bytes ignored", rate, 1);
    // pending still /64 from command mode; commit from command mode
    mode = 1'b0;
    send(8'h11, 1'b1, "R6 echo");
    echo_complete();
    check(rate == 3'd4, "R9 pending kept through data mode", rate, 4);

    // R10: pins override at once
    @(negedge clk); sel = 3'd3;
    @(negedge clk);
    check(rate == 3'd3, "R10 pin override", rate, 3);
    check(cen == 1'b1, "R5 codec_en pins", cen, 1);
    spacing(g);
    check(g == 8, "R11 spacing after override", g, 8);

    // R4: re-entry to software selection restores slowest rate
    sel = 3'b111; cyc(2);
    check(rate == 3'd0, "R4 software default on re-entry", rate, 0);

    // R1: reset mid-run
    sel = 3'd4; cyc(3); rst_n = 1'b0; cyc(2); rst_n = 1'b1; sel = 3'd0;
    @(negedge clk);
    check(rate == 3'd0, "R1 rate after reset", rate, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    timed_out = 1;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule